// File: doc/BRIEF.md
# Command-Stream Register Bridge

This block turns a stream of 16-bit words taken from a command FIFO into single register accesses on a simple local bus. A host, typically behind a USB peripheral controller, packs each access as a fixed four-word packet. The first word carries an operation code in its top four bits and a length field below it. Two address words follow, low half first, and a final word carries either the write data or, for a read, a transfer count. The bridge assembles the 32-bit address and then performs one of two actions. For a write it raises a one-cycle write strobe with the data. For a read it raises a one-cycle read strobe, samples the returned data on the following cycle, and pushes that word into a return FIFO.

The command FIFO is of the first-word-fall-through kind: `cmd_q` shows the head word whenever `cmd_empty` is low, and a cycle with `cmd_rd` high consumes it. The return FIFO accepts `ret_data` in any cycle where `ret_wr` is high. A synchronous active-low clear abandons a packet that is only partly received. An asynchronous active-low reset starts the bridge idle.

Top module: `cmd_reg_bridge`

## Requirements
- R1: After reset, `bus_wren`, `bus_rden` and `ret_wr` are low, and `cmd_rd` stays low while the command FIFO is empty.
- R2: `cmd_rd` is raised only while `cmd_empty` is low, and it consumes exactly one word per cycle. All four words of a packet are consumed, including a final word that is ignored.
- R3: A header whose bits [15:12] equal 4'b1000 starts a write. After the low-address, high-address and data words, `bus_wren` is high for exactly one cycle. In that cycle `bus_addr` = {high word, low word} and `bus_wdata` = the data word.
- R4: A header whose bits [15:12] equal 4'b1001 starts a read. After the two address words and one further word, whose value is ignored, `bus_rden` is high for exactly one cycle with `bus_addr` = {high word, low word}. No write strobe is raised.
- R5: The value of `bus_rdata` in the cycle right after the read-strobe cycle is the one captured. It is pushed into the return FIFO as exactly one word on `ret_data` with `ret_wr`.
- R6: `ret_wr` is never high while `ret_full` is high. The bridge waits in its push step until `ret_full` falls, then pushes once.
- R7: A header word whose bits [15:12] are neither code is consumed alone and dropped. The next word is treated as a new header.
- R8: `clr_n` low at a clock edge returns the bridge to waiting for a header and discards a partly received packet. While `clr_n` is low, no word is consumed.
- R9: No command word is consumed during a write strobe, a read strobe, the capture cycle or the push step. The next packet starts only after the current strobe or push is done.
- R10: The length field in header bits [11:0] does not affect the access. Headers 16'h8FFF and 16'h9000 behave as a write and a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_n | input | 1 | Synchronous clear, active low |
| cmd_empty | input | 1 | Command FIFO empty |
| cmd_q | input | 16 | Command FIFO head word |
| cmd_rd | output | 1 | Consume head word of command FIFO |
| ret_full | input | 1 | Return FIFO full |
| ret_wr | output | 1 | Push `ret_data` into return FIFO |
| ret_data | output | 16 | Read result word |
| bus_addr | output | 32 | Local bus address |
| bus_wdata | output | 16 | Local bus write data |
| bus_wren | output | 1 | One-cycle write strobe |
| bus_rden | output | 1 | One-cycle read strobe |
| bus_rdata | input | 16 | Local bus read data |

## Verification
The bus model in the bench drives `bus_rdata` with a different value during the strobe cycle, the capture cycle and the push cycle. A bridge that samples one cycle early or late therefore returns a wrong word. Words are fed both as complete packets and one at a time with gaps, so a parser that consumes a word from an empty FIFO, or that loses its position, builds a wrong address. Holding the return FIFO full with a second packet queued shows a bridge that pushes into a full FIFO, or that starts the next packet early. Unknown codes and a clear in the middle of a packet are each followed by a good write whose address and data would come out shifted if the parser kept stale words.

// File: rtl/cmdbr_pkg.sv
package cmdbr_pkg;
    localparam int WORD_W = 16;
    localparam int FUNC_W = 4;
    localparam int ADDR_W = 2 * WORD_W;
    localparam logic [FUNC_W-1:0] FN_WRITE = 4'b1000;
    localparam logic [FUNC_W-1:0] FN_READ  = 4'b1001;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ALO, ST_AHI, ST_TAIL, ST_WSTB, ST_RSTB, ST_CAP, ST_PUSH
    } st_e;

    typedef struct packed {
        st_e               st;
        logic              rd_op;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } ctx_t;
endpackage

// File: rtl/hdr_decode.sv
module hdr_decode
    import cmdbr_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int F = FUNC_W
) (
    input  logic [W-1:0] word,
    output logic         ok,
    output logic         is_rd
);
    logic [F-1:0] code;
    assign code  = word[W-1 -: F];
    assign ok    = (code == FN_WRITE) || (code == FN_READ);
    assign is_rd = (code == FN_READ);
endmodule

// File: rtl/bridge_fsm.sv
module bridge_fsm
    import cmdbr_pkg::*;
#(
    parameter int W = WORD_W,
    localparam int AW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_n,
    input  logic          cmd_empty,
    input  logic [W-1:0]  cmd_q,
    input  logic          hdr_ok,
    input  logic          hdr_rd,
    output logic          cmd_rd,
    input  logic          ret_full,
    output logic          ret_wr,
    output logic [W-1:0]  ret_data,
    output logic [AW-1:0] bus_addr,
    output logic [W-1:0]  bus_wdata,
    output logic          bus_wren,
    output logic          bus_rden,
    input  logic [W-1:0]  bus_rdata
);
    ctx_t ctx_d, ctx_q;
    logic accepting, take;

    assign accepting = (ctx_q.st == ST_IDLE) || (ctx_q.st == ST_ALO) ||
                       (ctx_q.st == ST_AHI)  || (ctx_q.st == ST_TAIL);
    assign take = accepting && !cmd_empty && clr_n;

    always_comb begin
        ctx_d = ctx_q;
        case (ctx_q.st)
            ST_IDLE: if (take && hdr_ok) begin
                ctx_d.rd_op = hdr_rd;
                ctx_d.st    = ST_ALO;
            end
            ST_ALO: if (take) begin
                ctx_d.addr[W-1:0] = cmd_q;
                ctx_d.st          = ST_AHI;
            end
            ST_AHI: if (take) begin
                ctx_d.addr[AW-1:W] = cmd_q;
                ctx_d.st           = ST_TAIL;
            end
            ST_TAIL: if (take) begin
                if (ctx_q.rd_op) begin
                    ctx_d.st = ST_RSTB;
                end else begin
                    ctx_d.data = cmd_q;
                    ctx_d.st   = ST_WSTB;
                end
            end
            ST_WSTB: ctx_d.st = ST_IDLE;
            ST_RSTB: ctx_d.st = ST_CAP;
            ST_CAP: begin
                ctx_d.data = bus_rdata;
                ctx_d.st   = ST_PUSH;
            end
            ST_PUSH: if (!ret_full) ctx_d.st = ST_IDLE;
            default: ctx_d.st = ST_IDLE;
        endcase
        if (!clr_n) ctx_d.st = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, rd_op: 1'b0, addr: '0, data: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign cmd_rd    = take;
    assign bus_wren  = (ctx_q.st == ST_WSTB);
    assign bus_rden  = (ctx_q.st == ST_RSTB);
    assign ret_wr    = (ctx_q.st == ST_PUSH) && !ret_full;
    assign ret_data  = ctx_q.data;
    assign bus_addr  = ctx_q.addr;
    assign bus_wdata = ctx_q.data;

    p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd |-> !cmd_empty);
    p_wren_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wren |=> !bus_wren);
    p_rden_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rden |=> !bus_rden && !bus_wren);
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_wr |-> !ret_full);
    p_push_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_wr |=> !ret_wr);
    p_clear_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> !bus_wren && !bus_rden && !ret_wr);
    p_no_pop_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wren || bus_rden || ret_wr) |-> !cmd_rd);
    p_addr_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rden |=> $stable(bus_addr));
endmodule

// File: rtl/cmd_reg_bridge.sv
module cmd_reg_bridge
    import cmdbr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_n,
    input  logic               cmd_empty,
    input  logic [WORD_W-1:0]  cmd_q,
    output logic               cmd_rd,
    input  logic               ret_full,
    output logic               ret_wr,
    output logic [WORD_W-1:0]  ret_data,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [WORD_W-1:0]  bus_wdata,
    output logic               bus_wren,
    output logic               bus_rden,
    input  logic [WORD_W-1:0]  bus_rdata
);
    logic hdr_ok, hdr_rd;

    hdr_decode #(.W(WORD_W), .F(FUNC_W)) u_dec (
        .word  (cmd_q),
        .ok    (hdr_ok),
        .is_rd (hdr_rd)
    );

    bridge_fsm #(.W(WORD_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (clr_n),
        .cmd_empty (cmd_empty),
        .cmd_q     (cmd_q),
        .hdr_ok    (hdr_ok),
        .hdr_rd    (hdr_rd),
        .cmd_rd    (cmd_rd),
        .ret_full  (ret_full),
        .ret_wr    (ret_wr),
        .ret_data  (ret_data),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wren  (bus_wren),
        .bus_rden  (bus_rden),
        .bus_rdata (bus_rdata)
    );
endmodule

// File: tb/cmd_reg_bridge_test.sv
module cmd_reg_bridge_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst_n = 1'b0;
    logic clr_n = 1'b1;
    logic [15:0] cmd_mem [0:255];
    logic [7:0] wrp = 8'd0;
    logic [7:0] rdp = 8'd0;
    logic cmd_empty, cmd_rd;
    logic [15:0] cmd_q;
    logic ret_full = 1'b0;
    logic ret_wr, bus_wren, bus_rden;
    logic [15:0] ret_data, bus_wdata;
    logic [31:0] bus_addr;
    logic [15:0] bus_rdata = 16'hBEEF;

    assign cmd_empty = (wrp == rdp);
    assign cmd_q     = cmd_mem[rdp];

    cmd_reg_bridge uut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
        .cmd_empty(cmd_empty), .cmd_q(cmd_q), .cmd_rd(cmd_rd),
        .ret_full(ret_full), .ret_wr(ret_wr), .ret_data(ret_data),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wren(bus_wren), .bus_rden(bus_rden), .bus_rdata(bus_rdata)
    );

    function automatic logic [15:0] rfunc(input logic [31:0] a);
        return ~a[15:0] ^ a[31:16];
    endfunction

    int nchk = 0, nfail = 0;
    bit done = 0;
    int wr_cnt = 0, rd_cnt = 0, ret_cnt = 0, viol = 0;
    logic [31:0] last_waddr = '0, last_raddr = '0, pend_addr = '0;
    logic [15:0] last_wdata = '0, last_ret = '0;
    logic pop_pend = 1'b0, cap_pend = 1'b0;

    // monitor and bus model, sampled a quarter period after the falling edge
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        pop_pend = cmd_rd;
        if (bus_wren) begin wr_cnt++; last_waddr = bus_addr; last_wdata = bus_wdata; end
        if (ret_wr) begin ret_cnt++; last_ret = ret_data; end
        if ((bus_wren || bus_rden || ret_wr) && cmd_rd) viol++;
        if (bus_rden) begin
            rd_cnt++; last_raddr = bus_addr; pend_addr = bus_addr;
            cap_pend = 1'b1; bus_rdata = 16'hDEAD;
        end else if (cap_pend) begin
            cap_pend = 1'b0; bus_rdata = rfunc(pend_addr);
        end else begin
            bus_rdata = 16'hBEEF;
        end
    end

    always @(posedge clk) if (pop_pend) rdp <= rdp + 8'd1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_word(input logic [15:0] w);
        cmd_mem[wrp] = w;
        wrp = wrp + 8'd1;
    endtask

    task automatic push_cmd(input logic rd, input logic [31:0] a, input logic [15:0] wd);
        push_word({rd ? 4'b1001 : 4'b1000, 12'd4});
        push_word(a[15:0]);
        push_word(a[31:16]);
        push_word(rd ? 16'd2 : wd);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    localparam int NV = 6;
    localparam logic [48:0] VEC [NV] = '{
        {1'b0, 32'h0000_0010, 16'h1234},
        {1'b1, 32'h0000_0010, 16'h0000},
        {1'b0, 32'hFFFF_FFFE, 16'hFFFF},
        {1'b1, 32'h8000_0001, 16'h0000},
        {1'b0, 32'h1234_5678, 16'h0000},
        {1'b1, 32'hFFFF_FFFF, 16'h0000}
    };

    initial begin
        int w0, r0, d0;
        wait_cyc(3);
        // R1 reset state
        chk("R1 wren", bus_wren, 0);
        chk("R1 rden", bus_rden, 0);
        chk("R1 ret_wr", ret_wr, 0);
        chk("R1 cmd_rd", cmd_rd, 0);
        rst_n = 1'b1;
        wait_cyc(2);

        // table walk: R3, R4, R5, R2
        for (int i = 0; i < NV; i++) begin
            w0 = wr_cnt; r0 = ret_cnt; d0 = rd_cnt;
            push_cmd(VEC[i][48], VEC[i][47:16], VEC[i][15:0]);
            wait_cyc(12);
            chk("R2 all words consumed", rdp, wrp);
            if (VEC[i][48]) begin
                chk("R4 one read strobe", rd_cnt, d0 + 1);
                chk("R4 read address", last_raddr, VEC[i][47:16]);
                chk("R4 no write strobe", wr_cnt, w0);
                chk("R5 one push", ret_cnt, r0 + 1);
                chk("R5 captured data", last_ret, rfunc(VEC[i][47:16]));
            end else begin
                chk("R3 one write strobe", wr_cnt, w0 + 1);
                chk("R3 write address", last_waddr, VEC[i][47:16]);
                chk("R3 write data", last_wdata, VEC[i][15:0]);
                chk("R3 no push", ret_cnt, r0);
            end
        end

        // R2 words fed one at a time with gaps
        w0 = wr_cnt;
        push_word(16'h8004); wait_cyc(3);
        push_word(16'h0A0A); wait_cyc(3);
        push_word(16'h0B0B); wait_cyc(3);
        chk("R2 no early strobe", wr_cnt, w0);
        push_word(16'h7777); wait_cyc(6);
        chk("R2 slow feed write", wr_cnt, w0 + 1);
        chk("R2 slow feed address", last_waddr, 32'h0B0B_0A0A);
        chk("R2 slow feed data", last_wdata, 16'h7777);

        // R7 unknown codes dropped
        w0 = wr_cnt; d0 = rd_cnt;
        push_word(16'h3004);
        push_word(16'hF004);
        push_cmd(1'b0, 32'hCAFE_0042, 16'h00AA);
        wait_cyc(14);
        chk("R7 single write after bad headers", wr_cnt, w0 + 1);
        chk("R7 no read", rd_cnt, d0);
        chk("R7 address", last_waddr, 32'hCAFE_0042);
        chk("R7 data", last_wdata, 16'h00AA);

        // R10 length field ignored
        w0 = wr_cnt; r0 = ret_cnt;
        push_word(16'h8FFF); push_word(16'h0001); push_word(16'h0002); push_word(16'h5555);
        push_word(16'h9000); push_word(16'h0303); push_word(16'h0404); push_word(16'h0002);
        wait_cyc(20);
        chk("R10 write with length FFF", wr_cnt, w0 + 1);
        chk("R10 write address", last_waddr, 32'h0002_0001);
        chk("R10 read with length 0", ret_cnt, r0 + 1);
        chk("R10 read data", last_ret, rfunc(32'h0404_0303));

        // R8 clear abandons a partial packet
        w0 = wr_cnt;
        push_word(16'h8004); push_word(16'h1111);
        wait_cyc(4);
        clr_n = 1'b0;
        wait_cyc(1);
        clr_n = 1'b1;
        push_cmd(1'b0, 32'hAAAA_BBBB, 16'h4321);
        wait_cyc(12);
        chk("R8 one write after clear", wr_cnt, w0 + 1);
        chk("R8 address", last_waddr, 32'hAAAA_BBBB);
        chk("R8 data", last_wdata, 16'h4321);

        // R6 / R9 return FIFO full stalls the bridge
        w0 = wr_cnt; r0 = ret_cnt; d0 = rd_cnt;
        ret_full = 1'b1;
        push_cmd(1'b1, 32'h0000_0C0C, 16'h0);
        wait_cyc(12);
        chk("R6 read issued", rd_cnt, d0 + 1);
        chk("R6 no push while full", ret_cnt, r0);
        push_cmd(1'b0, 32'h0000_0D0D, 16'h9999);
        wait_cyc(8);
        chk("R9 next packet held during push", wr_cnt, w0);
        ret_full = 1'b0;
        wait_cyc(14);
        chk("R6 exactly one push", ret_cnt, r0 + 1);
        chk("R6 pushed data", last_ret, rfunc(32'h0000_0C0C));
        chk("R9 queued write done", wr_cnt, w0 + 1);
        chk("R9 queued write address", last_waddr, 32'h0000_0D0D);

        // R9 back-to-back packets
        w0 = wr_cnt; r0 = ret_cnt;
        push_cmd(1'b0, 32'h0101_0202, 16'h1111);
        push_cmd(1'b0, 32'h0303_0404, 16'h2222);
        push_cmd(1'b1, 32'h0505_0606, 16'h0);
        wait_cyc(30);
        chk("R9 two writes", wr_cnt, w0 + 2);
        chk("R9 second write data", last_wdata, 16'h2222);
        chk("R9 read pushed", ret_cnt, r0 + 1);
        chk("R9 read data", last_ret, rfunc(32'h0505_0606));
        chk("R9 no pop during strobe or push", viol, 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule